// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table in memory. A caller offers a virtual address together with the current table base. The walker then issues one or two descriptor reads on a memory read port that allows a single read in flight. It decodes what comes back and reports the physical address, the cacheable and bufferable attributes, the domain number and the two access-permission bits for the addressed location. A descriptor marked invalid produces a translation fault, and the result says whether the fault came from the first or the second level.

Four mapping sizes are supported: 1 MB sections mapped straight from the first level, and 64 KB, 4 KB and 1 KB pages mapped through a second-level table. There are two kinds of second-level table. A coarse table is 1 KB, is indexed by VA[19:12] and holds 64 KB and 4 KB pages. A fine table is 4 KB, is indexed by VA[19:10] and also holds 1 KB pages. 64 KB and 4 KB page descriptors carry four permission fields, one for each quarter of the page, and the walker returns the field for the quarter the address falls in.

Handshake rules. The request port accepts a transfer when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` is high only while the walker is idle. On the read request port the walker raises `rd_valid` and holds it, with `rd_addr` stable, until the edge where `rd_ready` is high. On the read response port the walker raises `rsp_ready` only while it waits for data and takes `rsp_data` on the edge where `rsp_valid` is high. There is no time-out on either read phase. The result is shown for exactly one cycle by `res_done`, and the result fields keep their value until the next walk completes.

Top module: `xw_walker`

## Requirements
- R1: The first-level descriptor is read from address {tbl_base[31:14], VA[31:20], 2'b00}, using the VA and base captured when the request is accepted.
- R2: A first-level descriptor of type 2'b10 (bits 1:0) is a section. The result is PA = {desc[31:20], VA[19:0]}, bufferable = desc[2], cacheable = desc[3], domain = desc[8:5], permission = desc[11:10], with no fault. The walk makes exactly one read.
- R3: A first-level descriptor of type 2'b00 ends the walk after one read, with res_fault = 1 and res_fault_l2 = 0.
- R4: A first-level descriptor of type 2'b01 (coarse) leads to a second read at {desc[31:10], VA[19:12], 2'b00}. The domain in the result is first-level desc[8:5].
- R5: A first-level descriptor of type 2'b11 (fine) leads to a second read at {desc[31:12], VA[19:10], 2'b00}. The domain in the result is first-level desc[8:5].
- R6: A second-level descriptor of type 2'b01 is a 64 KB page. The result is PA = {desc[31:16], VA[15:0]}, with the permission taken from desc[2*s+5 : 2*s+4] where s = VA[15:14].
- R7: A second-level descriptor of type 2'b10 is a 4 KB page. The result is PA = {desc[31:12], VA[11:0]}, with the permission taken from desc[2*s+5 : 2*s+4] where s = VA[11:10].
- R8: In a fine table, a second-level descriptor of type 2'b11 is a 1 KB page. The result is PA = {desc[31:10], VA[9:0]}, with the permission taken from desc[5:4]. For every page size, bufferable is desc[2] and cacheable is desc[3].
- R9: A second-level descriptor of type 2'b00, or of type 2'b11 in a coarse table, gives res_fault = 1 and res_fault_l2 = 1.
- R10: rd_valid stays high with rd_addr stable until rd_ready is seen. The walker waits for rsp_valid as long as it takes, and rsp_ready is high only while it waits and never at the same time as rd_valid.
- R11: req_ready is high only while idle, so no request is taken during a walk. res_done rises in the cycle after the last response is taken, lasts one cycle, and is followed by req_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | Translation table base, captured with the request |
| rd_valid | output | 1 | Descriptor read request valid |
| rd_ready | input | 1 | Memory accepts the read request |
| rd_addr | output | 32 | Descriptor address |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Walker waiting for read data |
| rsp_data | input | 32 | Descriptor word |
| res_done | output | 1 | One-cycle pulse when the result is ready |
| res_pa | output | 32 | Physical address |
| res_cacheable | output | 1 | Cacheable attribute |
| res_bufferable | output | 1 | Bufferable attribute |
| res_domain | output | 4 | Domain number |
| res_ap | output | 2 | Access-permission bits for the addressed subpage |
| res_fault | output | 1 | Translation fault |
| res_fault_l2 | output | 1 | Fault came from the second level |

## Verification
The bench targets the index bits that differ between coarse and fine tables. A walker that mixed them up would read a second-level descriptor from an address off by a factor of four. It uses four distinct permission fields and addresses in different page quarters, so that selecting the subpage with the wrong VA bits, or reading the fixed low field, shows up as a wrong permission. It checks that a tiny-page code in a coarse table and an invalid code at either level produce the right fault level, and that sections and first-level faults never issue a second read. Stalls on both read phases check that the address stays held and that requests are refused while a walk is running.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int ADDR_W = 32;
  localparam int DOM_W  = 4;
  localparam int AP_W   = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_st_e;

  typedef enum logic [1:0] {
    L1_FAULT = 2'b00, L1_COARSE = 2'b01, L1_SECTION = 2'b10, L1_FINE = 2'b11
  } l1_kind_e;

  typedef enum logic [1:0] {
    L2_FAULT = 2'b00, L2_LARGE = 2'b01, L2_SMALL = 2'b10, L2_TINY = 2'b11
  } l2_kind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] pa;
    logic              cacheable;
    logic              bufferable;
    logic [DOM_W-1:0]  domain;
    logic [AP_W-1:0]   ap;
    logic              fault;
    logic              fault_l2;
  } xlat_res_t;
endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
  import xw_pkg::*;
(
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] va,
  input  logic [ADDR_W-1:0] l1_desc,
  output logic [ADDR_W-1:0] l1_addr,
  output logic [ADDR_W-1:0] l2_addr
);
  logic is_fine;

  always_comb begin
    is_fine = (l1_desc[1:0] == L1_FINE);
    l1_addr = {tbl_base[31:14], va[31:20], 2'b00};
    if (is_fine) l2_addr = {l1_desc[31:12], va[19:10], 2'b00};
    else         l2_addr = {l1_desc[31:10], va[19:12], 2'b00};
  end
endmodule

// File: rtl/xw_l1_decode.sv
module xw_l1_decode
  import xw_pkg::*;
(
  input  logic [ADDR_W-1:0] desc,
  input  logic [ADDR_W-1:0] va,
  output logic              need_l2,
  output xlat_res_t         res
);
  l1_kind_e kind;

  always_comb begin
    kind    = l1_kind_e'(desc[1:0]);
    need_l2 = (kind == L1_COARSE) || (kind == L1_FINE);
    res     = '0;
    if (kind == L1_SECTION) begin
      res.pa         = {desc[31:20], va[19:0]};
      res.bufferable = desc[2];
      res.cacheable  = desc[3];
      res.domain     = desc[8:5];
      res.ap         = desc[11:10];
    end else if (kind == L1_FAULT) begin
      res.fault = 1'b1;
    end
  end
endmodule

// File: rtl/xw_l2_decode.sv
module xw_l2_decode
  import xw_pkg::*;
(
  input  logic [ADDR_W-1:0] desc,
  input  logic [ADDR_W-1:0] va,
  input  logic              in_fine,
  input  logic [DOM_W-1:0]  domain,
  output xlat_res_t         res
);
  localparam int NSUB = 4;
  l2_kind_e        kind;
  logic [AP_W-1:0] sub_ap [NSUB];

  // one permission field per quarter of the page
  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    assign sub_ap[g] = desc[4 + AP_W*g +: AP_W];
  end

  always_comb begin
    kind           = l2_kind_e'(desc[1:0]);
    res            = '0;
    res.domain     = domain;
    res.bufferable = desc[2];
    res.cacheable  = desc[3];
    unique case (kind)
      L2_LARGE: begin
        res.pa = {desc[31:16], va[15:0]};
        res.ap = sub_ap[va[15:14]];
      end
      L2_SMALL: begin
        res.pa = {desc[31:12], va[11:0]};
        res.ap = sub_ap[va[11:10]];
      end
      L2_TINY: begin
        if (in_fine) begin
          res.pa = {desc[31:10], va[9:0]};
          res.ap = sub_ap[0];
        end
      end
      default: ;
    endcase
    if (kind == L2_FAULT || (kind == L2_TINY && !in_fine)) begin
      res.fault      = 1'b1;
      res.fault_l2   = 1'b1;
      res.bufferable = 1'b0;
      res.cacheable  = 1'b0;
    end
  end
endmodule

// File: rtl/xw_walker.sv
module xw_walker
  import xw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic [31:0] tbl_base,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [31:0] rd_addr,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [31:0] rsp_data,
  output logic        res_done,
  output logic [31:0] res_pa,
  output logic        res_cacheable,
  output logic        res_bufferable,
  output logic [3:0]  res_domain,
  output logic [1:0]  res_ap,
  output logic        res_fault,
  output logic        res_fault_l2
);
  walk_st_e          st;
  logic [ADDR_W-1:0] va_q, base_q, l1_q;
  logic [ADDR_W-1:0] l1_addr, l2_addr;
  logic              need_l2;
  xlat_res_t         l1_res, l2_res, res_q;

  xw_addr_gen u_addr (
    .tbl_base (base_q), .va (va_q), .l1_desc (l1_q),
    .l1_addr (l1_addr), .l2_addr (l2_addr)
  );

  xw_l1_decode u_l1 (
    .desc (rsp_data), .va (va_q), .need_l2 (need_l2), .res (l1_res)
  );

  xw_l2_decode u_l2 (
    .desc (rsp_data), .va (va_q), .in_fine (l1_q[1:0] == L1_FINE),
    .domain (l1_q[8:5]), .res (l2_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      va_q   <= '0;
      base_q <= '0;
      l1_q   <= '0;
      res_q  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_va;
          base_q <= tbl_base;
          st     <= ST_L1_REQ;
        end
        ST_L1_REQ: if (rd_ready) st <= ST_L1_WAIT;
        ST_L1_WAIT: if (rsp_valid) begin
          l1_q <= rsp_data;
          if (need_l2) st <= ST_L2_REQ;
          else begin
            res_q <= l1_res;
            st    <= ST_DONE;
          end
        end
        ST_L2_REQ: if (rd_ready) st <= ST_L2_WAIT;
        ST_L2_WAIT: if (rsp_valid) begin
          res_q <= l2_res;
          st    <= ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready      = (st == ST_IDLE);
  assign rd_valid       = (st == ST_L1_REQ) || (st == ST_L2_REQ);
  assign rd_addr        = (st == ST_L2_REQ) ? l2_addr : l1_addr;
  assign rsp_ready      = (st == ST_L1_WAIT) || (st == ST_L2_WAIT);
  assign res_done       = (st == ST_DONE);
  assign res_pa         = res_q.pa;
  assign res_cacheable  = res_q.cacheable;
  assign res_bufferable = res_q.bufferable;
  assign res_domain     = res_q.domain;
  assign res_ap         = res_q.ap;
  assign res_fault      = res_q.fault;
  assign res_fault_l2   = res_q.fault_l2;

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  p_rsp_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !rd_valid);
  p_busy_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || rsp_ready || res_done) |-> !req_ready);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done && req_ready);
  p_l1_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_L1_WAIT && rsp_valid && rsp_data[1:0] == 2'b00)
      |=> res_done && res_fault && !res_fault_l2);
  p_section_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_L1_WAIT && rsp_valid && rsp_data[1:0] == 2'b10)
      |=> res_done && !rd_valid && !res_fault);
  p_fault_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_fault_l2 |-> res_fault);
endmodule

// File: tb/xw_walker_bench.sv
module xw_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, rd_ready = 1'b0, rsp_valid = 1'b0;
  logic [31:0] req_va = '0, tbl_base = '0, rsp_data = '0;
  logic        req_ready, rd_valid, rsp_ready, res_done;
  logic [31:0] rd_addr, res_pa;
  logic        res_cacheable, res_bufferable, res_fault, res_fault_l2;
  logic [3:0]  res_domain;
  logic [1:0]  res_ap;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  xw_walker u_xw_walker (
    .clk, .rst_n, .req_valid, .req_ready, .req_va, .tbl_base,
    .rd_valid, .rd_ready, .rd_addr, .rsp_valid, .rsp_ready, .rsp_data,
    .res_done, .res_pa, .res_cacheable, .res_bufferable, .res_domain,
    .res_ap, .res_fault, .res_fault_l2
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // serve one descriptor read with 'gap' stall cycles on each phase
  task automatic serve(string tag, logic [31:0] a, logic [31:0] d, int gap);
    for (int i = 0; i < gap; i++) begin
      chk({tag, " R10 rd_valid held"}, rd_valid, 1);
      chk({tag, " R11 busy"}, req_ready, 0);
      @(negedge clk);
    end
    chk({tag, " rd_valid"}, rd_valid, 1);
    chk({tag, " rd_addr"}, rd_addr, a);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    for (int i = 0; i < gap; i++) begin
      chk({tag, " R10 rsp_ready waits"}, rsp_ready, 1);
      chk({tag, " R10 no rd_valid"}, rd_valid, 0);
      @(negedge clk);
    end
    chk({tag, " R10 rsp_ready"}, rsp_ready, 1);
    rsp_valid = 1'b1;
    rsp_data  = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic walk(string tag, logic [31:0] va, logic [31:0] base,
                      logic [31:0] a1, logic [31:0] d1, bit two,
                      logic [31:0] a2, logic [31:0] d2, int gap,
                      logic [31:0] pa, logic c, logic b, logic [3:0] dom,
                      logic [1:0] ap, logic f, logic f2);
    @(negedge clk);
    chk({tag, " R11 idle ready"}, req_ready, 1);
    req_valid = 1'b1; req_va = va; tbl_base = base;
    @(negedge clk);
    req_valid = 1'b0; req_va = ~va; tbl_base = ~base;
    serve({tag, " R1 L1"}, a1, d1, gap);
    if (two) serve({tag, " L2"}, a2, d2, gap);
    chk({tag, " R11 done"}, res_done, 1);
    chk({tag, " no extra read"}, rd_valid, 0);
    chk({tag, " fault"}, res_fault, f);
    chk({tag, " fault_l2"}, res_fault_l2, f2);
    if (!f) begin
      chk({tag, " pa"}, res_pa, pa);
      chk({tag, " cacheable"}, res_cacheable, c);
      chk({tag, " bufferable"}, res_bufferable, b);
      chk({tag, " domain"}, res_domain, dom);
      chk({tag, " ap"}, res_ap, ap);
    end
    @(negedge clk);
    chk({tag, " R11 pulse ends"}, res_done, 0);
    chk({tag, " R11 ready again"}, req_ready, 1);
    chk({tag, " result held"}, res_fault, f);
  endtask

  function automatic logic [31:0] l1a(logic [31:0] base, logic [31:0] va);
    return {base[31:14], va[31:20], 2'b00};
  endfunction

  task automatic t_reset();
    chk("reset req_ready", req_ready, 1);
    chk("reset rd_valid", rd_valid, 0);
    chk("reset rsp_ready", rsp_ready, 0);
    chk("reset res_done", res_done, 0);
  endtask

  task automatic t_section_r2();
    logic [31:0] va = 32'h1234_5678, base = 32'h8000_4000;
    logic [31:0] d = {12'hABC, 8'h00, 2'b11, 1'b0, 4'h9, 1'b0, 1'b1, 1'b0, 2'b10};
    walk("R2 section", va, base, l1a(base, va), d, 0, 0, 0, 3,
         {12'hABC, va[19:0]}, 1, 0, 4'h9, 2'b11, 0, 0);
  endtask

  task automatic t_l1_fault_r3();
    logic [31:0] va = 32'hFFF0_0004, base = 32'h0001_C000;
    walk("R3 l1 fault", va, base, l1a(base, va), 32'hFFFF_FFFC, 0, 0, 0, 0,
         0, 0, 0, 0, 0, 1, 0);
  endtask

  // coarse L1 with domain 5, base 22'h2AAAA
  task automatic t_coarse_large_r6();
    logic [31:0] va = 32'h7654_AB21, base = 32'h4000_0000;
    logic [31:0] d1 = {22'h2AAAA, 1'b0, 4'h5, 3'b000, 2'b01};
    logic [31:0] d2 = {16'hBEEF, 4'h0, 2'b11, 2'b10, 2'b01, 2'b00, 1'b0, 1'b1, 2'b01};
    walk("R4 R6 large", va, base, l1a(base, va), d1, 1,
         {22'h2AAAA, va[19:12], 2'b00}, d2, 2,
         {16'hBEEF, va[15:0]}, 0, 1, 4'h5, 2'b10, 0, 0);
  endtask

  task automatic t_coarse_small_r7(logic [31:0] va, logic [1:0] ap);
    logic [31:0] base = 32'h0000_8000;
    logic [31:0] d1 = {22'h13579, 1'b0, 4'hC, 3'b000, 2'b01};
    logic [31:0] d2 = {20'hCAFE1, 2'b11, 2'b10, 2'b01, 2'b00, 1'b1, 1'b1, 2'b10};
    walk("R4 R7 small", va, base, l1a(base, va), d1, 1,
         {22'h13579, va[19:12], 2'b00}, d2, 1,
         {20'hCAFE1, va[11:0]}, 1, 1, 4'hC, ap, 0, 0);
  endtask

  task automatic t_fine_tiny_r8();
    logic [31:0] va = 32'h9ABC_DEF7, base = 32'hC000_0000;
    logic [31:0] d1 = {20'hF0F0F, 3'b000, 4'h3, 3'b000, 2'b11};
    logic [31:0] d2 = {22'h155AA, 4'h0, 2'b01, 1'b1, 1'b0, 2'b11};
    walk("R5 R8 tiny", va, base, l1a(base, va), d1, 1,
         {20'hF0F0F, va[19:10], 2'b00}, d2, 2,
         {22'h155AA, va[9:0]}, 1, 0, 4'h3, 2'b01, 0, 0);
  endtask

  task automatic t_l2_fault_r9(logic [1:0] l2type, string tag);
    logic [31:0] va = 32'h0003_F000, base = 32'h0000_4000;
    logic [31:0] d1 = {22'h00101, 1'b0, 4'h1, 3'b000, 2'b01};
    walk(tag, va, base, l1a(base, va), d1, 1,
         {22'h00101, va[19:12], 2'b00}, {30'h3FFF_FFFF, l2type}, 0,
         0, 0, 0, 0, 0, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_section_r2();
    t_l1_fault_r3();
    t_coarse_large_r6();
    t_coarse_small_r7(32'h0012_3C45, 2'b11);
    t_coarse_small_r7(32'h0012_3445, 2'b01);
    t_fine_tiny_r8();
    t_l2_fault_r9(2'b00, "R9 l2 invalid");
    t_l2_fault_r9(2'b11, "R9 tiny in coarse");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule